// File: doc/BRIEF.md
# Temporary Group Address Activator

This block sits behind the vector-word decoder of a paging receiver. It watches every decoded vector word for a short-instruction vector whose instruction requests temporary address activation. Each such instruction arms one of sixteen temporary group addresses for a single frame number. The armed addresses are held in a small table with one slot per temporary index.

A frame counter elsewhere in the receiver reports the current frame number with a tick strobe. While the current frame equals the frame armed for a slot, an address lookup that presents that slot's temporary address raises the match flag. The receiver therefore accepts the group message as if it were addressed to itself. Once the frame number moves on from the armed frame, the slot is released. The whole table is brought out for observation.

Top module: `grp_addr_activator`

## Requirements
- R1: After reset, and for two clock cycles after reset is released, every slot is empty (`armed_valid` all zero, `armed_frame` all zero), no current frame is known, and `match` is low.
- R2: Vector word fields are read by bit position: bits 6:4 hold the vector type, bits 9:7 hold the instruction type, bits 16:10 hold the target frame, and bits 20:17 hold the slot index. A word strobed with type 3'b001 (bit 4 set, bits 5 and 6 clear) and instruction 3'b000 arms slot index with the target frame. The slot is visible on `armed_valid`/`armed_frame` (slot i at bits i*7 +: 7) on the next clock.
- R3: A strobed word whose vector type is not 3'b001 leaves the table unchanged.
- R4: A short-instruction word whose instruction type is not 3'b000 leaves the table unchanged.
- R5: A new activation for an already armed slot replaces its target frame.
- R6: A `frame_tick` loads `frame_num` as the current frame from the next cycle on. Before the first tick, `match` stays low.
- R7: `match` is high exactly when a current frame is known, `chk_addr` equals base plus index for an armed slot, and that slot's target frame equals the current frame. It responds combinationally to `chk_addr`.
- R8: The temporary addresses are 21'h1F7800 through 21'h1F780F (the base has four zero low bits). Any other `chk_addr` never matches.
- R9: A tick that moves the current frame to a different value clears every slot armed for the frame being left. An activation in the same cycle for the same slot wins over the clear.
- R10: A tick clears no slot whose target frame differs from the frame being left, and a tick that repeats the current frame clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_valid | input | 1 | Strobe for `vec_word` |
| vec_word | input | 32 | Decoded vector codeword |
| frame_tick | input | 1 | Strobe for `frame_num` |
| frame_num | input | 7 | Current frame number |
| chk_addr | input | 21 | Address under lookup |
| match | output | 1 | Lookup hits an armed slot in its frame |
| armed_valid | output | 16 | Per-slot armed flag |
| armed_frame | output | 112 | Per-slot target frame, slot i at bits i*7 +: 7 |

## Verification
Directed sequences first separate the decode conditions from one another: a word with the right type but the wrong instruction, a word with the wrong type but a zero instruction field, and a proper activation before any frame is known. These show that arming and matching each depend on every field. Frame transitions are then tried in three forms: onto a different frame, repeating the same frame, and coinciding with a write to the slot being cleared. These distinguish "leave" from "tick" and settle the write-over-clear priority. A long random phase follows. It draws frame numbers from a narrow set so that armed frames are revisited, and lookup addresses from just inside and just outside the reserved range. A behavioural model compares the match flag and the whole table on every cycle.

// File: rtl/grp_act_pkg.sv
package grp_act_pkg;
  localparam int WORD_W    = 32;
  localparam int TYPE_LSB  = 4;
  localparam int TYPE_W    = 3;
  localparam int INSTR_LSB = 7;
  localparam int INSTR_W   = 3;
  localparam int FRM_LSB   = 10;
  localparam int IDX_LSB   = 17;

  localparam logic [TYPE_W-1:0]  SHORT_INSTR_TYPE = 3'b001;
  localparam logic [INSTR_W-1:0] TEMP_ACT_INSTR   = 3'b000;
endpackage

// File: rtl/grp_rst_sync.sv
module grp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/grp_vec_decode.sv
module grp_vec_decode
  import grp_act_pkg::*;
#(
  parameter int FRAME_W = 7,
  parameter int IDX_W   = 4
) (
  input  logic               vec_valid,
  input  logic [WORD_W-1:0]  vec_word,
  output logic               act,
  output logic [IDX_W-1:0]   act_idx,
  output logic [FRAME_W-1:0] act_frame
);
  logic [TYPE_W-1:0]  vtype;
  logic [INSTR_W-1:0] instr;
  logic               unused_bits;

  always_comb begin
    vtype     = vec_word[TYPE_LSB  +: TYPE_W];
    instr     = vec_word[INSTR_LSB +: INSTR_W];
    act_frame = vec_word[FRM_LSB   +: FRAME_W];
    act_idx   = vec_word[IDX_LSB   +: IDX_W];
    act       = vec_valid && (vtype == SHORT_INSTR_TYPE) && (instr == TEMP_ACT_INSTR);
  end

  assign unused_bits = ^{vec_word[WORD_W-1:IDX_LSB+IDX_W], vec_word[TYPE_LSB-1:0]};
endmodule

// File: rtl/grp_frame_track.sv
module grp_frame_track #(
  parameter int FRAME_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_tick,
  input  logic [FRAME_W-1:0] frame_num,
  output logic [FRAME_W-1:0] cur_frame,
  output logic               cur_ok,
  output logic               leave
);
  logic [FRAME_W-1:0] cur_frame_d, cur_frame_q;
  logic               cur_ok_d, cur_ok_q;
  logic               upd_en;

  always_comb begin
    cur_frame_d = cur_frame_q;
    cur_ok_d    = cur_ok_q;
    upd_en      = frame_tick;
    if (frame_tick) begin
      cur_frame_d = frame_num;
      cur_ok_d    = 1'b1;
    end
    leave = frame_tick && cur_ok_q && (frame_num != cur_frame_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_frame_q <= '0;
      cur_ok_q    <= 1'b0;
    end else if (upd_en) begin
      cur_frame_q <= cur_frame_d;
      cur_ok_q    <= cur_ok_d;
    end
  end

  assign cur_frame = cur_frame_q;
  assign cur_ok    = cur_ok_q;
endmodule

// File: rtl/grp_entry_table.sv
module grp_entry_table #(
  parameter int FRAME_W = 7,
  parameter int IDX_W   = 4,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [FRAME_W-1:0]         wr_frame,
  input  logic                       leave,
  input  logic [FRAME_W-1:0]         leave_frame,
  output logic [ENTRIES-1:0]         ent_valid,
  output logic [ENTRIES*FRAME_W-1:0] ent_frame
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic               v_d, v_q;
    logic [FRAME_W-1:0] f_d, f_q;
    logic               hit_wr, hit_clr, en;

    always_comb begin
      hit_wr  = wr && (wr_idx == IDX_W'(i));
      hit_clr = leave && v_q && (f_q == leave_frame);
      en      = hit_wr || hit_clr;
      v_d     = v_q;
      f_d     = f_q;
      if (hit_clr) v_d = 1'b0;
      if (hit_wr) begin
        v_d = 1'b1;
        f_d = wr_frame;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        f_q <= '0;
      end else if (en) begin
        v_q <= v_d;
        f_q <= f_d;
      end
    end

    assign ent_valid[i]                   = v_q;
    assign ent_frame[i*FRAME_W +: FRAME_W] = f_q;
  end
endmodule

// File: rtl/grp_addr_match.sv
module grp_addr_match #(
  parameter int               FRAME_W   = 7,
  parameter int               IDX_W     = 4,
  parameter int               ADDR_W    = 21,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 21'h1F7800,
  localparam int              ENTRIES   = 1 << IDX_W
) (
  input  logic [ADDR_W-1:0]          chk_addr,
  input  logic [FRAME_W-1:0]         cur_frame,
  input  logic                       cur_ok,
  input  logic [ENTRIES-1:0]         ent_valid,
  input  logic [ENTRIES*FRAME_W-1:0] ent_frame,
  output logic                       match
);
  logic               in_range;
  logic [IDX_W-1:0]   sel;
  logic [FRAME_W-1:0] sel_frame;
  logic               unused_base;

  always_comb begin
    in_range  = (chk_addr[ADDR_W-1:IDX_W] == BASE_ADDR[ADDR_W-1:IDX_W]);
    sel       = chk_addr[IDX_W-1:0];
    sel_frame = ent_frame[sel*FRAME_W +: FRAME_W];
    match     = cur_ok && in_range && ent_valid[sel] && (sel_frame == cur_frame);
  end

  assign unused_base = ^BASE_ADDR[IDX_W-1:0];
endmodule

// File: rtl/grp_addr_activator.sv
module grp_addr_activator
  import grp_act_pkg::*;
#(
  parameter int               FRAME_W   = 7,
  parameter int               IDX_W     = 4,
  parameter int               ADDR_W    = 21,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 21'h1F7800
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             vec_valid,
  input  logic [WORD_W-1:0]                vec_word,
  input  logic                             frame_tick,
  input  logic [FRAME_W-1:0]               frame_num,
  input  logic [ADDR_W-1:0]                chk_addr,
  output logic                             match,
  output logic [(1<<IDX_W)-1:0]            armed_valid,
  output logic [(1<<IDX_W)*FRAME_W-1:0]    armed_frame
);
  logic               rst_sync_n;
  logic               act;
  logic [IDX_W-1:0]   act_idx;
  logic [FRAME_W-1:0] act_frame;
  logic [FRAME_W-1:0] cur_frame;
  logic               cur_ok;
  logic               leave;

  grp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  grp_vec_decode #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_dec (
    .vec_valid (vec_valid),
    .vec_word  (vec_word),
    .act       (act),
    .act_idx   (act_idx),
    .act_frame (act_frame)
  );

  grp_frame_track #(.FRAME_W(FRAME_W)) u_frm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .frame_tick (frame_tick),
    .frame_num  (frame_num),
    .cur_frame  (cur_frame),
    .cur_ok     (cur_ok),
    .leave      (leave)
  );

  grp_entry_table #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_tab (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr          (act),
    .wr_idx      (act_idx),
    .wr_frame    (act_frame),
    .leave       (leave),
    .leave_frame (cur_frame),
    .ent_valid   (armed_valid),
    .ent_frame   (armed_frame)
  );

  grp_addr_match #(
    .FRAME_W(FRAME_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_match (
    .chk_addr  (chk_addr),
    .cur_frame (cur_frame),
    .cur_ok    (cur_ok),
    .ent_valid (armed_valid),
    .ent_frame (armed_frame),
    .match     (match)
  );
endmodule

// File: rtl/grp_addr_activator_chk.sv
module grp_addr_activator_chk #(
  parameter int               FRAME_W   = 7,
  parameter int               IDX_W     = 4,
  parameter int               ADDR_W    = 21,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 21'h1F7800
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          vec_valid,
  input logic [31:0]                   vec_word,
  input logic                          frame_tick,
  input logic [ADDR_W-1:0]             chk_addr,
  input logic                          match,
  input logic [(1<<IDX_W)-1:0]         armed_valid,
  input logic [(1<<IDX_W)*FRAME_W-1:0] armed_frame
);
  logic               is_short, is_act;
  logic [IDX_W-1:0]   w_idx;
  logic [FRAME_W-1:0] w_frm;
  logic               in_rng;

  assign is_short = vec_valid && (vec_word[6:4] == 3'b001);
  assign is_act   = is_short && (vec_word[9:7] == 3'b000);
  assign w_idx    = vec_word[17 +: IDX_W];
  assign w_frm    = vec_word[10 +: FRAME_W];
  assign in_rng   = (chk_addr[ADDR_W-1:IDX_W] == BASE_ADDR[ADDR_W-1:IDX_W]);

  // R1: table empty on the first active cycle
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (armed_valid == '0 && armed_frame == '0 && !match));

  // R2: activation arms the addressed slot
  p_arm_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> (armed_valid[$past(w_idx)] &&
                armed_frame[$past(w_idx)*FRAME_W +: FRAME_W] == $past(w_frm)));

  // R3: other vector types leave the table alone
  p_ignore_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !is_short && !frame_tick) |=> ($stable(armed_valid) && $stable(armed_frame)));

  // R4: other instruction types leave the table alone
  p_ignore_instr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_short && !is_act && !frame_tick) |=> ($stable(armed_valid) && $stable(armed_frame)));

  // R7: a match needs the addressed slot armed
  p_match_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> armed_valid[chk_addr[IDX_W-1:0]]);

  // R8: nothing outside the reserved range matches
  p_out_of_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rng |-> !match);

  // R10: with no strobe, the table holds
  p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_valid && !frame_tick) |=> ($stable(armed_valid) && $stable(armed_frame)));
endmodule

bind grp_addr_activator grp_addr_activator_chk #(
  .FRAME_W(FRAME_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .vec_valid   (vec_valid),
  .vec_word    (vec_word),
  .frame_tick  (frame_tick),
  .chk_addr    (chk_addr),
  .match       (match),
  .armed_valid (armed_valid),
  .armed_frame (armed_frame)
);

// File: tb/grp_addr_activator_bench.sv
`timescale 1ns/1ps
module grp_addr_activator_bench;
  localparam int ENT = 16;
  localparam logic [20:0] BASE = 21'h1F7800;

  logic         clk;
  logic         rst_n;
  logic         vec_valid;
  logic [31:0]  vec_word;
  logic         frame_tick;
  logic [6:0]   frame_num;
  logic [20:0]  chk_addr;
  logic         match;
  logic [15:0]  armed_valid;
  logic [111:0] armed_frame;

  grp_addr_activator u_grp_addr_activator (
    .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_word(vec_word),
    .frame_tick(frame_tick), .frame_num(frame_num), .chk_addr(chk_addr),
    .match(match), .armed_valid(armed_valid), .armed_frame(armed_frame)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int    n_vec  = 0;
  int    n_bad  = 0;
  string cur_req = "R1";
  bit    done   = 0;

  int m_v [ENT];
  int m_f [ENT];
  int m_cur;
  int m_ok;

  function automatic logic [31:0] mk(input int vt, input int ins, input int frm, input int idx);
    logic [31:0] w;
    w = $urandom();
    w[6:4]   = 3'(vt);
    w[9:7]   = 3'(ins);
    w[16:10] = 7'(frm);
    w[20:17] = 4'(idx);
    return w;
  endfunction

  task automatic compare();
    logic exp_match;
    int   k;
    bit   bad;
    bad = 0;
    exp_match = 0;
    if (m_ok != 0 && chk_addr[20:4] == BASE[20:4]) begin
      k = int'(chk_addr[3:0]);
      exp_match = (m_v[k] != 0) && (m_f[k] == m_cur);
    end
    n_vec++;
    if (match !== exp_match) begin
      $display("FAIL %s match: got %0b expected %0b (addr %h)", cur_req, match, exp_match, chk_addr);
      bad = 1;
    end
    for (int i = 0; i < ENT; i++) begin
      if (armed_valid[i] !== (m_v[i] != 0) ||
          (m_v[i] != 0 && armed_frame[i*7 +: 7] !== 7'(m_f[i])) ||
          (m_v[i] == 0 && armed_valid[i] === 1'b0 && armed_frame[i*7 +: 7] === 7'bx)) begin
        $display("FAIL %s slot %0d: got valid %0b frame %0d expected valid %0d frame %0d",
                 cur_req, i, armed_valid[i], armed_frame[i*7 +: 7], m_v[i], m_f[i]);
        bad = 1;
      end
    end
    if (bad) n_bad++;
  endtask

  // drive at negedge, compare, then apply the model update for the coming edge
  task automatic step(input logic vv, input logic [31:0] w, input logic tk,
                      input int fn, input logic [20:0] ad);
    vec_valid  = vv;
    vec_word   = w;
    frame_tick = tk;
    frame_num  = 7'(fn);
    chk_addr   = ad;
    #1;
    compare();
    if (tk) begin
      if (m_ok != 0 && fn != m_cur)
        for (int i = 0; i < ENT; i++)
          if (m_v[i] != 0 && m_f[i] == m_cur) m_v[i] = 0;
      m_cur = fn;
      m_ok  = 1;
    end
    if (vv && w[6:4] == 3'b001 && w[9:7] == 3'b000) begin
      m_v[int'(w[20:17])] = 1;
      m_f[int'(w[20:17])] = int'(w[16:10]);
    end
    @(negedge clk);
  endtask

  task automatic idle(input logic [20:0] ad);
    step(1'b0, 32'h0, 1'b0, 0, ad);
  endtask

  initial begin
    #400000;
    $display("FAIL watchdog: got timeout expected completion");
    n_bad++;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENT; i++) begin m_v[i] = 0; m_f[i] = 0; end
    m_cur = 0; m_ok = 0;
    vec_valid = 0; vec_word = 0; frame_tick = 0; frame_num = 0; chk_addr = BASE;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state through the synchroniser window
    cur_req = "R1";
    repeat (3) idle(BASE);

    // R6: armed slot cannot match before any frame is known
    cur_req = "R6";
    step(1'b1, mk(1, 0, 0, 3), 1'b0, 0, BASE + 3);
    idle(BASE + 3);
    step(1'b0, 32'h0, 1'b1, 0, BASE + 3);
    // R7: now current frame 0 equals slot 3 target
    cur_req = "R7";
    idle(BASE + 3);
    idle(BASE + 4);
    // R8: addresses just outside the range
    cur_req = "R8";
    idle(BASE + 3 + 16);
    idle(BASE - 1);
    idle(21'h0F7803);
    // R3: wrong vector type, zero instruction
    cur_req = "R3";
    step(1'b1, mk(5, 0, 0, 9), 1'b0, 0, BASE + 9);
    idle(BASE + 9);
    // R4: right type, other instruction
    cur_req = "R4";
    step(1'b1, mk(1, 2, 0, 10), 1'b0, 0, BASE + 10);
    idle(BASE + 10);
    // R5: overwrite slot 3 with frame 9
    cur_req = "R5";
    step(1'b1, mk(1, 0, 9, 3), 1'b0, 0, BASE + 3);
    idle(BASE + 3);
    // R2: arm slot 7 for frame 0 and slot 15 for frame 0
    cur_req = "R2";
    step(1'b1, mk(1, 0, 0, 7), 1'b0, 0, BASE + 7);
    step(1'b1, mk(1, 0, 0, 15), 1'b0, 0, BASE + 7);
    idle(BASE + 15);
    // R10: repeating frame 0 clears nothing
    cur_req = "R10";
    step(1'b0, 32'h0, 1'b1, 0, BASE + 7);
    idle(BASE + 7);
    // R9: leave frame 0 while rewriting slot 15 for frame 0: write wins, slot 7 clears
    cur_req = "R9";
    step(1'b1, mk(1, 0, 0, 15), 1'b1, 9, BASE + 3);
    idle(BASE + 3);
    idle(BASE + 7);
    idle(BASE + 15);

    // random phase covering R2..R10 together
    cur_req = "R2/R3/R4/R5/R7/R8/R9/R10";
    for (int n = 0; n < 4000; n++) begin
      logic        vv, tk;
      int          fn, vt, ins;
      logic [20:0] ad;
      vv  = ($urandom_range(0, 2) == 0);
      tk  = ($urandom_range(0, 4) == 0);
      fn  = $urandom_range(0, 5);
      vt  = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 7) : 1;
      ins = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : 0;
      case ($urandom_range(0, 5))
        0:       ad = BASE + 21'd16 + 21'($urandom_range(0, 15));
        1:       ad = BASE - 21'd1 - 21'($urandom_range(0, 15));
        default: ad = BASE + 21'($urandom_range(0, 15));
      endcase
      step(vv, mk(vt, ins, $urandom_range(0, 5), $urandom_range(0, 15)), tk, fn, ad);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule